// File: doc/BRIEF.md
# Error-Locator Polynomial Solver (binary Berlekamp, GF(2^13))

This block takes the 2t syndromes of a binary BCH codeword over GF(2^13) and finds the error-locator polynomial sigma(x) and its degree. It uses the simplified binary form of the Berlekamp iteration. A decoder pipeline places it between a syndrome generator and a root search. The caller applies the syndrome vector and the runtime correction capability t, then pulses `start`. A few dozen cycles later `done` pulses for one cycle. The locator coefficients and the degree then stay on the outputs until the next start.

Internally the solver keeps one table row per step. Each row holds the step index mu, the discrepancy, the doubled degree, delta and a sigma polynomial. The solver walks rows 1..t. When the discrepancy of a row is non-zero, it builds the next row from the current row and an earlier correction row. That correction term is scaled by a field quotient, which a small inverter finds by repeated squaring. When the discrepancy is zero, the row is carried forward unchanged. After a computed number of zero discrepancies the search ends early. The result is always the row with index t+1.

Top module: `bm_locator_solver`

## Requirements
- R1: After reset, `done` is low, `degree` is 0 and every `sigma` coefficient is 0.
- R2: When every syndrome is zero, the result is sigma(x) = 1: coefficient 0 equals 1, all other coefficients are 0, and the degree is 0.
- R3: When the syndromes come from v distinct error locations and v <= t, the `degree` output equals v.
- R4: Field elements are 13-bit polynomials reduced by x^13+x^4+x^3+x+1. The primitive element alpha is 13'h0002. `synd[j-1]` carries S_j = sum over errors of alpha^(j*loc). In the result, `sigma[0]` = 1 and sigma(alpha^(-loc)) = 0 for every injected location loc, where `sigma[k]` is the coefficient of x^k.
- R5: A non-zero discrepancy at row i corrects with the earlier row rho that has a non-zero discrepancy and the largest delta; on a tie the lowest row wins. The new degree is the larger of deg_i and deg_rho + (mu_i - mu_rho), so the degree never shrinks from row to row.
- R6: The correction term is (d_i / d_rho) * x^(mu_i - mu_rho) * sigma_rho. The quotient is formed with the inverse d_rho^(2^13-2).
- R7: After a zero discrepancy at row i, the run ends with row i as the result when the zero count reaches q/2 + (q odd ? 2 : 1), where q = t - deg_i - 1 and the division truncates toward zero. With t = 8 and all-zero syndromes, `done` is high 9 cycles after the clock edge that samples `start`.
- R8: `done` is high for exactly one cycle. `sigma` and `degree` hold their values until the next start. Changes on `synd` or `tSel` without a start have no effect on them.
- R9: Only S_1..S_2t are used. Entries of `synd` at index 2t and above have no effect on the result.
- R10: With t = 1 and a single error, the result is sigma(x) = 1 + S_1 x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a solve; sampled only while idle |
| tSel | input | $clog2(T+1) | Runtime correction capability t, 1..T |
| synd | input | 2T x 13 | Syndromes; element j-1 holds S_j |
| sigma | output | (T+1) x 13 | Locator coefficients; element k multiplies x^k |
| degree | output | $clog2(T+1) | Degree of the locator |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The assertions assume that `tSel` lies in 1..T and that the syndromes describe a binary code word with at most t flipped bits. Under that assumption every correction row has a non-zero discrepancy and the locator degree stays within the table. The random stimulus holds to this: t is drawn from 1..T, the error count from 0..t, and the locations are distinct exponents below 8191. The syndromes are built from those locations. The unused upper syndrome entries are filled with noise so that R9 is exercised. Directed cases cover the all-zero syndrome vector, t = 1 with one error, and t = T with T errors.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int GF_M = 13;
  localparam logic [GF_M-1:0] GF_POLY_LOW = 13'h001B;

  typedef logic [GF_M-1:0] gfElem;

  typedef struct packed {
    logic load;
    logic copyRow;
    logic copyFinal;
    logic invStart;
    logic update;
    logic advance;
  } bmStrobe_t;

  typedef struct packed {
    logic discZero;
    logic zeroHit;
    logic invDone;
    logic lastIter;
  } bmStatus_t;

  function automatic gfElem gfMul(gfElem a, gfElem b);
    gfElem acc;
    gfElem sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < GF_M; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = sh[GF_M-1] ? ((sh << 1) ^ GF_POLY_LOW) : (sh << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  bmStatus_t stat,
  output bmStrobe_t stb,
  output logic      done
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_INV, S_UPD, S_NEXT, S_FIN} state_t;
  state_t state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      S_IDLE: if (start) begin
        stb.load = 1'b1;
        nxt = S_EVAL;
      end
      S_EVAL: begin
        if (stat.discZero) begin
          if (stat.zeroHit) begin
            stb.copyFinal = 1'b1;
            nxt = S_FIN;
          end else begin
            stb.copyRow = 1'b1;
            nxt = S_NEXT;
          end
        end else begin
          stb.invStart = 1'b1;
          nxt = S_INV;
        end
      end
      S_INV: if (stat.invDone) nxt = S_UPD;
      S_UPD: begin
        stb.update = 1'b1;
        nxt = S_NEXT;
      end
      S_NEXT: begin
        stb.advance = 1'b1;
        nxt = stat.lastIter ? S_FIN : S_EVAL;
      end
      S_FIN: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign done = (state == S_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_FIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(stat.zeroHit) || $past(stat.lastIter))); // R7
endmodule

// File: rtl/bm_dp.sv
module bm_dp
  import bm_pkg::*;
#(
  parameter  int T  = 8,
  localparam int DW = $clog2(T + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  bmStrobe_t                  stb,
  input  logic [2*T-1:0][GF_M-1:0]   synd,
  input  logic [DW-1:0]              tIn,
  output bmStatus_t                  stat,
  output logic [T:0][GF_M-1:0]       sigmaOut,
  output logic [DW-1:0]              degOut
);
  localparam int NCOEF = 2 * T + 1;
  localparam int NROW  = T + 2;
  localparam int IW    = $clog2(T + 2);
  localparam int CW    = $clog2(NCOEF);
  localparam int SXW   = $clog2(2 * T);
  localparam int VW    = $clog2(4 * T + 4) + 1;
  localparam int ICW   = $clog2(GF_M);

  typedef logic signed [VW-1:0] sval_t;

  logic [NCOEF-1:0][GF_M-1:0] sigRow [NROW];
  gfElem                      disc   [NROW];
  sval_t                      mu     [NROW];
  sval_t                      lmu    [NROW];
  sval_t                      delta  [NROW];
  logic [2*T-1:0][GF_M-1:0]   syndQ;
  logic [IW-1:0]              iQ, nI, dzc, finalIdx;
  logic [DW-1:0]              tQ;
  gfElem                      invSq, invAcc, sqNext;
  logic [ICW-1:0]             invCnt;
  logic                       invRun;

  assign nI       = iQ + IW'(1);
  assign finalIdx = IW'(tQ) + IW'(1);

  // correction row: non-zero discrepancy, largest delta, earliest on tie
  logic [IW-1:0] rho;
  sval_t         largest;
  always_comb begin
    rho     = '0;
    largest = -1;
    for (int j = 0; j < NROW; j++) begin
      if (j < int'(iQ) && disc[j] != '0 && delta[j] > largest) begin
        largest = delta[j];
        rho     = IW'(j);
      end
    end
  end

  sval_t diff, degI, degR, newLmu;
  int    diffI;
  gfElem factor;
  assign diff   = mu[iQ] - mu[rho];
  assign diffI  = int'(diff);
  assign degI   = lmu[iQ] >>> 1;
  assign degR   = lmu[rho] >>> 1;
  assign newLmu = (degI > degR + diff) ? lmu[iQ] : ((degR + diff) <<< 1);
  assign factor = gfMul(disc[iQ], invAcc);

  logic [NCOEF-1:0][GF_M-1:0] updRow;
  always_comb begin
    for (int k = 0; k < NCOEF; k++) begin
      updRow[k] = sigRow[iQ][k];
      if (k >= diffI && k - diffI < NCOEF)
        updRow[k] = updRow[k] ^ gfMul(factor, sigRow[rho][CW'(k - diffI)]);
    end
  end

  // discrepancy of the freshly written row i+1
  gfElem nextDisc;
  int    degN;
  assign degN = int'(lmu[nI] >>> 1);
  always_comb begin
    nextDisc = '0;
    if (2 * int'(iQ) < 2 * T) begin
      nextDisc = syndQ[SXW'(2 * int'(iQ))];
      for (int k = 1; k <= T; k++) begin
        if (k <= degN && 2 * int'(iQ) - k >= 0)
          nextDisc = nextDisc ^ gfMul(sigRow[nI][k], syndQ[SXW'(2 * int'(iQ) - k)]);
      end
    end
  end

  // zero-discrepancy stop limit
  int remI, limitI;
  always_comb begin
    remI   = int'(tQ) - int'(lmu[iQ] >>> 1) - 1;
    limitI = remI / 2 + (((remI & 1) != 0) ? 2 : 1);
  end

  assign sqNext        = gfMul(invSq, invSq);
  assign stat.discZero = (disc[iQ] == '0);
  assign stat.zeroHit  = (int'(dzc) + 1 == limitI);
  assign stat.invDone  = invRun && (invCnt == '0);
  assign stat.lastIter = (iQ >= IW'(tQ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NROW; r++) begin
        sigRow[r] <= '0;
        disc[r]   <= '0;
        mu[r]     <= '0;
        lmu[r]    <= '0;
        delta[r]  <= '0;
      end
      syndQ  <= '0;
      iQ     <= '0;
      dzc    <= '0;
      tQ     <= '0;
      invSq  <= '0;
      invAcc <= '0;
      invCnt <= '0;
      invRun <= 1'b0;
    end else begin
      if (stb.load) begin
        for (int r = 0; r < NROW; r++) begin
          sigRow[r] <= '0;
          disc[r]   <= '0;
          lmu[r]    <= '0;
          delta[r]  <= '0;
          mu[r]     <= sval_t'(2 * (r - 1));
        end
        sigRow[0][0] <= gfElem'(1);
        mu[0]        <= -1;
        disc[0]      <= gfElem'(1);
        delta[0]     <= -1;
        sigRow[1][0] <= gfElem'(1);
        disc[1]      <= synd[0];
        syndQ        <= synd;
        tQ           <= tIn;
        iQ           <= IW'(1);
        dzc          <= '0;
      end
      if (stb.copyRow) begin
        sigRow[nI] <= sigRow[iQ];
        lmu[nI]    <= lmu[iQ];
        dzc        <= dzc + IW'(1);
      end
      if (stb.copyFinal) begin
        sigRow[finalIdx] <= sigRow[iQ];
        lmu[finalIdx]    <= lmu[iQ];
        dzc              <= dzc + IW'(1);
      end
      if (stb.update) begin
        sigRow[nI] <= updRow;
        lmu[nI]    <= newLmu;
        invRun     <= 1'b0;
      end
      if (stb.advance) begin
        delta[nI] <= ((mu[nI] <<< 1) - lmu[nI]) >>> 1;
        if (!stat.lastIter) disc[nI] <= nextDisc;
        iQ <= nI;
      end
      // inverse by repeated squaring: a^(2^M-2)
      if (stb.invStart) begin
        invSq  <= disc[rho];
        invAcc <= gfElem'(1);
        invCnt <= ICW'(GF_M - 1);
        invRun <= 1'b1;
      end else if (invRun && invCnt != '0) begin
        invSq  <= sqNext;
        invAcc <= gfMul(invAcc, sqNext);
        invCnt <= invCnt - ICW'(1);
      end
    end
  end

  always_comb begin
    for (int k = 0; k <= T; k++) sigmaOut[k] = sigRow[finalIdx][k];
  end
  assign degOut = DW'(lmu[finalIdx] >>> 1);

  AST_INV_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    stat.invDone |-> (gfMul(invAcc, disc[rho]) == gfElem'(1))); // R6

  AST_RHO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    stb.invStart |-> (disc[rho] != '0 && rho < iQ)); // R5

  AST_DEG_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.advance |-> (lmu[nI] >= lmu[iQ])); // R5

  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    dzc <= iQ); // R7
endmodule

// File: rtl/bm_locator_solver.sv
module bm_locator_solver
  import bm_pkg::*;
#(
  parameter  int T  = 8,
  localparam int DW = $clog2(T + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [DW-1:0]            tSel,
  input  logic [2*T-1:0][GF_M-1:0] synd,
  output logic [T:0][GF_M-1:0]     sigma,
  output logic [DW-1:0]            degree,
  output logic                     done
);
  bmStrobe_t stb;
  bmStatus_t stat;

  bm_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stat  (stat),
    .stb   (stb),
    .done  (done)
  );

  bm_dp #(.T(T)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .synd     (synd),
    .tIn      (tSel),
    .stat     (stat),
    .sigmaOut (sigma),
    .degOut   (degree)
  );
endmodule

// File: tb/bm_locator_solver_bench.sv
module bm_locator_solver_bench;
  localparam int T  = 8;
  localparam int M  = 13;
  localparam int NQ = 8191;
  localparam int DW = $clog2(T + 1);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [DW-1:0]         tSel = '0;
  logic [2*T-1:0][M-1:0] synd = '0;
  logic [T:0][M-1:0]     sigma;
  logic [DW-1:0]         degree;
  logic                  done;

  int nChecks = 0;
  int nFail = 0;
  bit reported = 0;
  int locs [T];

  always #5 clk = ~clk;

  bm_locator_solver #(.T(T)) u_bm_locator_solver (
    .clk(clk), .rst_n(rst_n), .start(start), .tSel(tSel),
    .synd(synd), .sigma(sigma), .degree(degree), .done(done)
  );

  function automatic logic [M-1:0] xt(logic [M-1:0] a);
    return a[M-1] ? ((a << 1) ^ 13'h001B) : (a << 1);
  endfunction

  function automatic logic [M-1:0] fMul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] p = '0;
    for (int i = M - 1; i >= 0; i--) begin
      p = xt(p);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [M-1:0] fPow(int e);
    logic [M-1:0] r = 13'h1;
    logic [M-1:0] b = 13'h2;
    int ee = e % NQ;
    while (ee > 0) begin
      if (ee & 1) r = fMul(r, b);
      b = fMul(b, b);
      ee = ee >> 1;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] evalSig(logic [T:0][M-1:0] s, logic [M-1:0] x);
    logic [M-1:0] acc = '0;
    for (int k = T; k >= 0; k--) acc = fMul(acc, x) ^ s[k];
    return acc;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pickLocs(int n);
    for (int e = 0; e < n; e++) begin
      bit dup;
      do begin
        locs[e] = $urandom % NQ;
        dup = 0;
        for (int q = 0; q < e; q++) if (locs[q] == locs[e]) dup = 1;
      end while (dup);
    end
  endtask

  // builds syndromes, runs the solver, returns latency in cycles
  task automatic runCase(int tv, int nerr, bit zeroAll, output int lat);
    logic [2*T-1:0][M-1:0] s;
    for (int j = 1; j <= 2 * T; j++) begin
      logic [M-1:0] v = '0;
      if (zeroAll) v = '0;
      else if (j <= 2 * tv) begin
        for (int e = 0; e < nerr; e++) v = v ^ fPow(locs[e] * j);
      end else v = M'($urandom);
      s[j-1] = v;
    end
    @(negedge clk);
    synd = s; tSel = DW'(tv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    check(done, "R3", "done seen", int'(done), 1);
  endtask

  task automatic checkResult(int tv, int nerr);
    string tag;
    tag = (tv < T) ? "R4 R5 R6 R9" : "R4 R5 R6";
    check(int'(degree) == nerr, "R3", "degree", int'(degree), nerr);
    check(sigma[0] == 13'h1, "R4", "sigma0", int'(sigma[0]), 1);
    for (int e = 0; e < nerr; e++) begin
      logic [M-1:0] r = evalSig(sigma, fPow(NQ - locs[e]));
      check(r == '0, tag, "sigma at root", int'(r), 0);
    end
  endtask

  task automatic holdCheck();
    logic [T:0][M-1:0] sv = sigma;
    logic [DW-1:0]     dv = degree;
    check(!done, "R8", "done one cycle", int'(done), 0);
    synd = '1; tSel = DW'(T);
    repeat (4) @(negedge clk);
    check(sigma == sv, "R8", "sigma held", int'(sigma[1]), int'(sv[1]));
    check(degree == dv, "R8", "degree held", int'(degree), int'(dv));
    check(!done, "R8", "no stray done", int'(done), 0);
  endtask

  initial begin
    int lat;
    void'($urandom(32'h5EED_0B11));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done, "R1", "done after reset", int'(done), 0);
    check(degree == '0, "R1", "degree after reset", int'(degree), 0);
    check(sigma == '0, "R1", "sigma after reset", int'(sigma[0]), 0);

    // all-zero syndromes, full capability: early stop
    runCase(T, 0, 1'b1, lat);
    check(lat == 9, "R7", "latency zero syndromes", lat, 9);
    check(degree == '0, "R2", "degree zero syndromes", int'(degree), 0);
    check(sigma[0] == 13'h1, "R2", "sigma0 zero syndromes", int'(sigma[0]), 1);
    for (int k = 1; k <= T; k++)
      check(sigma[k] == '0, "R2", "upper coef zero syndromes", int'(sigma[k]), 0);
    @(negedge clk);
    holdCheck();

    // t = 1, one error
    pickLocs(1);
    runCase(1, 1, 1'b0, lat);
    check(sigma[1] == fPow(locs[0]), "R10", "sigma1 equals S1", int'(sigma[1]), int'(fPow(locs[0])));
    checkResult(1, 1);

    // t = T, T errors
    pickLocs(T);
    runCase(T, T, 1'b0, lat);
    checkResult(T, T);
    @(negedge clk);
    holdCheck();

    // random mix
    for (int it = 0; it < 60; it++) begin
      int tv = 1 + ($urandom % T);
      int ne = $urandom % (tv + 1);
      pickLocs(ne);
      runCase(tv, ne, 1'b0, lat);
      checkResult(tv, ne);
    end

    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!reported) begin
      reported = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule